// File: doc/BRIEF.md
# Set/Clear Interrupt Register Group

This block collects the interrupt events of a serial peripheral into one level-sensitive request line. It keeps a sticky status register with seven event bits, an enable mask that software changes only through two write-only registers (one that sets mask bits and one that clears them), and a read-only view of that mask. The request line is high whenever any status bit is set and its mask bit is also set.

Three of the events come from FIFO occupancy. The transmit-low event is set while the transmit FIFO holds fewer entries than a programmable watermark. The transmit-full event is set while that FIFO is at its full depth. The receive-ready event is set while the receive FIFO holds anything. Every bit can also be set by a one-cycle event pulse input, so the mode-fault source and the unassigned bits arrive as pulses. The FIFOs and the serial engine sit outside the block and supply only their fill levels.

Register access uses a simple synchronous write strobe with a byte address. Reads are combinational from the address.

Top module: `intc_top`

## Requirements
- R1: After reset the status and mask registers read 0, the watermark register reads 1 and `irq` is low.
- R2: Status reads at address 0x04 in bits [6:0], with the upper bits zero. Status bits are sticky: once set, a bit stays set until software clears it.
- R3: A write to 0x04 clears every status bit whose data bit is 1 and leaves the 0 bits alone, so writing back a value just read clears exactly the bits that were set.
- R4: When a status bit is cleared in the same cycle that its event is present, the clear wins for that cycle. If a level condition still holds, the bit reads 1 again one cycle later.
- R5: Writing 1s to address 0x08 sets the matching mask bits, and writing 1s to 0x0C clears them. Zero bits leave the mask unchanged. The mask reads at 0x10, and both 0x08 and 0x0C read as 0.
- R6: Status bit 2 is set on the clock edge after a cycle in which `txLevel` is less than the watermark. The watermark is read and written at 0x28 in bits [7:0].
- R7: Status bit 3 is set after a cycle in which `txLevel` equals the FIFO depth (128).
- R8: Status bit 4 is set after a cycle in which `rxLevel` is nonzero.
- R9: Any bit of `pulseEvt` that is high for one cycle sets the same status bit. Bit 1 carries the mode fault.
- R10: `irq` equals the OR over all bits of (status AND mask) in every cycle, and it is low whenever the mask is zero.
- R11: A write to the mask view at 0x10 or to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| pulseEvt | input | 7 | One-cycle event pulses, one per status bit |
| txLevel | input | 8 | Transmit FIFO fill level, 0 to 128 |
| rxLevel | input | 8 | Receive FIFO fill level |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
A wrong internal state appears at the ports in two ways. `irq` shows it in the same cycle, because the line is a pure function of status and mask. A read of status, mask or watermark shows it one cycle after the stimulus that caused it. The random phase therefore compares `irq` every cycle and compares a register on every read cycle, so a corrupted mask or status bit is caught within a few cycles of its cause. The directed cases cover the clear-versus-event collision, the watermark edge (level equal to the threshold against one below it) and the exact full depth, because these decide a single bit on a single cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC = 7;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  // status / mask bit positions decoded by software
  localparam int BIT_MODF   = 1;
  localparam int BIT_TXLOW  = 2;
  localparam int BIT_TXFULL = 3;
  localparam int BIT_RXNE   = 4;

  typedef struct packed {
    logic stsClr;
    logic maskSet;
    logic maskClr;
    logic thrWr;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STS  = 2'd1,
    RD_MASK = 2'd2,
    RD_THR  = 2'd3
  } rdSel_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STS_OFS  = 8'h04,
  parameter logic [ADDR_W-1:0] SET_OFS  = 8'h08,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 8'h0C,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] THR_OFS  = 8'h28
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobe_t        strobe,
  output rdSel_t            rdSel
);
  always_comb begin
    strobe         = '0;
    strobe.stsClr  = regWr && (regAddr == STS_OFS);
    strobe.maskSet = regWr && (regAddr == SET_OFS);
    strobe.maskClr = regWr && (regAddr == CLR_OFS);
    strobe.thrWr   = regWr && (regAddr == THR_OFS);
  end

  always_comb begin
    unique case (regAddr)
      STS_OFS:  rdSel = RD_STS;
      MASK_OFS: rdSel = RD_MASK;
      THR_OFS:  rdSel = RD_THR;
      default:  rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/intc_bitcell.sv
module intc_bitcell (
  input  logic clk,
  input  logic rstN,
  input  logic setIn,
  input  logic clrIn,
  output logic q
);
  // a clear beats a set in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)      q <= 1'b0;
    else if (clrIn) q <= 1'b0;
    else if (setIn) q <= 1'b1;
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int THR_RST    = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  rdSel_t             rdSel,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] pulseEvt,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   rxLevel,
  output logic [NUM_SRC-1:0] stsQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);
  localparam int WD_USED = (LVL_W > NUM_SRC) ? LVL_W : NUM_SRC;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic [LVL_W-1:0]   thrQ;
  logic [NUM_SRC-1:0] levelEvt;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] stsClrBits;
  logic [NUM_SRC-1:0] maskSetBits;
  logic [NUM_SRC-1:0] maskClrBits;
  logic               unusedWdata;

  assign unusedWdata = ^wdata[DATA_W-1:WD_USED];

  always_comb begin
    levelEvt             = '0;
    levelEvt[BIT_TXLOW]  = txLevel < thrQ;
    levelEvt[BIT_TXFULL] = txLevel == FULL_LVL;
    levelEvt[BIT_RXNE]   = rxLevel != '0;
  end

  assign evt         = pulseEvt | levelEvt;
  assign stsClrBits  = strobe.stsClr  ? wdata[NUM_SRC-1:0] : '0;
  assign maskSetBits = strobe.maskSet ? wdata[NUM_SRC-1:0] : '0;
  assign maskClrBits = strobe.maskClr ? wdata[NUM_SRC-1:0] : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    intc_bitcell u_sts (
      .clk(clk), .rstN(rstN), .setIn(evt[i]), .clrIn(stsClrBits[i]), .q(stsQ[i])
    );
    intc_bitcell u_mask (
      .clk(clk), .rstN(rstN), .setIn(maskSetBits[i]), .clrIn(maskClrBits[i]), .q(maskQ[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)             thrQ <= LVL_W'(THR_RST);
    else if (strobe.thrWr) thrQ <= wdata[LVL_W-1:0];
  end

  always_comb begin
    unique case (rdSel)
      RD_STS:  rdata = DATA_W'(stsQ);
      RD_MASK: rdata = DATA_W'(maskQ);
      RD_THR:  rdata = DATA_W'(thrQ);
      default: rdata = '0;
    endcase
  end

  assign irq = |(stsQ & maskQ);
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] pulseEvt,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   rxLevel,
  output logic               irq
);
  ctlStrobe_t         strobe;
  rdSel_t             rdSel;
  logic [NUM_SRC-1:0] stsQ;
  logic [NUM_SRC-1:0] maskQ;

  intc_ctrl u_ctrl (
    .regWr(regWr), .regAddr(regAddr), .strobe(strobe), .rdSel(rdSel)
  );

  intc_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .THR_RST(1)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .wdata(regWdata),
    .pulseEvt(pulseEvt), .txLevel(txLevel), .rxLevel(rxLevel),
    .stsQ(stsQ), .maskQ(maskQ), .rdata(regRdata), .irq(irq)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWr,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic [LVL_W-1:0]   rxLevel,
  input logic [NUM_SRC-1:0] stsQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic               irq
);
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 8'h08) |=> ((maskQ & $past(regWdata[NUM_SRC-1:0])) == $past(regWdata[NUM_SRC-1:0]))); // R5

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 8'h0C) |=> ((maskQ & $past(regWdata[NUM_SRC-1:0])) == '0)); // R5

  AST_STS_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 8'h04) |=> ((stsQ & $past(regWdata[NUM_SRC-1:0])) == '0)); // R4

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regAddr == 8'h04) |=> ((stsQ & $past(stsQ)) == $past(stsQ))); // R2

  AST_RX_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel != '0 && !(regWr && regAddr == 8'h04 && regWdata[4])) |=> stsQ[4]); // R8

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq); // R10

  AST_MASK_VIEW_RO: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 8'h10) |=> $stable(maskQ)); // R11
endmodule

bind intc_top intc_checker #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_intc_top.sv
`timescale 1ns/1ps
module sim_intc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [6:0]  pulseEvt = '0;
  logic [7:0]  txLevel = 8'd64;
  logic [7:0]  rxLevel = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [6:0] mSts, mMask;
  logic [7:0] mThr;

  always #4 clk = ~clk;

  intc_top u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .pulseEvt(pulseEvt), .txLevel(txLevel), .rxLevel(rxLevel), .irq(irq)
  );

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h04:   return {25'd0, mSts};
      8'h10:   return {25'd0, mMask};
      8'h28:   return {24'd0, mThr};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [6:0] expEvents(logic [6:0] p, logic [7:0] tx, logic [7:0] rx, logic [7:0] thr);
    logic [6:0] e;
    e = p;
    if (tx < thr)     e[2] = 1'b1;
    if (tx == 8'd128) e[3] = 1'b1;
    if (rx != 8'd0)   e[4] = 1'b1;
    return e;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, check reads and irq, update model at posedge
  task automatic cyc(string req, bit wr, logic [7:0] a, logic [31:0] d,
                     logic [6:0] p, logic [7:0] tx, logic [7:0] rx);
    logic [6:0] ev, clr;
    @(negedge clk);
    regWr = wr; regAddr = a; regWdata = d; pulseEvt = p; txLevel = tx; rxLevel = rx;
    #1;
    if (!wr) check(req, regRdata, expRead(a));
    check("R10", {31'd0, irq}, {31'd0, |(mSts & mMask)});
    @(posedge clk);
    ev  = expEvents(p, tx, rx, mThr);
    clr = (wr && a == 8'h04) ? d[6:0] : 7'd0;
    mSts = (mSts & ~clr) | (ev & ~clr);
    if (wr && a == 8'h08) mMask = mMask | d[6:0];
    if (wr && a == 8'h0C) mMask = mMask & ~d[6:0];
    if (wr && a == 8'h28) mThr  = d[7:0];
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    mSts = '0; mMask = '0; mThr = 8'd1;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset values
    cyc("R1", 0, 8'h04, 0, 0, 64, 0); check("R1", regRdata, 32'd0);
    cyc("R1", 0, 8'h10, 0, 0, 64, 0); check("R1", regRdata, 32'd0);
    cyc("R1", 0, 8'h28, 0, 0, 64, 0); check("R1", regRdata, 32'd1);
    check("R1", {31'd0, irq}, 32'd0);

    // R9 pulses, R2 sticky, R3 write-back clears exactly
    cyc("R9", 0, 8'h04, 0, 7'h63, 64, 0);
    cyc("R2", 0, 8'h04, 0, 0, 64, 0); check("R9", regRdata, 32'h63);
    cyc("R2", 0, 8'h04, 0, 0, 64, 0); check("R2", regRdata, 32'h63);
    cyc("R3", 1, 8'h04, 32'h63, 0, 64, 0);
    cyc("R3", 0, 8'h04, 0, 0, 64, 0); check("R3", regRdata, 32'h0);
    cyc("R9", 0, 8'h04, 0, 7'h0A, 64, 0);
    cyc("R3", 1, 8'h04, 32'hFFFF_FF02, 0, 64, 0);
    cyc("R3", 0, 8'h04, 0, 0, 64, 0); check("R3", regRdata, 32'h08);
    cyc("R3", 1, 8'h04, 32'h08, 0, 64, 0);

    // R5 mask set/clear, write-only reads 0, R10 irq follows
    cyc("R5", 1, 8'h08, 32'h15, 0, 64, 0);
    cyc("R5", 0, 8'h10, 0, 0, 64, 0); check("R5", regRdata, 32'h15);
    cyc("R5", 0, 8'h08, 0, 0, 64, 0); check("R5", regRdata, 32'h0);
    cyc("R5", 1, 8'h0C, 32'h05, 0, 64, 0);
    cyc("R5", 0, 8'h10, 0, 0, 64, 0); check("R5", regRdata, 32'h10);
    // R11 writes to mask view and unmapped address ignored
    cyc("R11", 1, 8'h10, 32'h7F, 0, 64, 0);
    cyc("R11", 1, 8'h3C, 32'h7F, 0, 64, 0);
    cyc("R11", 0, 8'h10, 0, 0, 64, 0); check("R11", regRdata, 32'h10);
    cyc("R11", 0, 8'h28, 0, 0, 64, 0); check("R11", regRdata, 32'h1);

    // R8 rx not empty, R10 irq, R4 clear collides with held level
    cyc("R8", 0, 8'h04, 0, 0, 64, 3);
    cyc("R8", 0, 8'h04, 0, 0, 64, 3); check("R8", regRdata, 32'h10);
    check("R10", {31'd0, irq}, 32'd1);
    cyc("R4", 1, 8'h04, 32'h10, 0, 64, 3);
    cyc("R4", 0, 8'h04, 0, 0, 64, 3); check("R4", regRdata, 32'h00);
    cyc("R4", 0, 8'h04, 0, 0, 64, 0); check("R4", regRdata, 32'h10);
    cyc("R4", 1, 8'h04, 32'h10, 0, 64, 0);
    cyc("R10", 0, 8'h04, 0, 0, 64, 0); check("R10", {31'd0, irq}, 32'd0);

    // R6 watermark edge
    cyc("R6", 1, 8'h28, 32'h20, 0, 64, 0);
    cyc("R6", 0, 8'h28, 0, 0, 32, 0); check("R6", regRdata, 32'h20);
    cyc("R6", 0, 8'h04, 0, 0, 64, 0); check("R6", regRdata, 32'h00);
    cyc("R6", 0, 8'h04, 0, 0, 31, 0);
    cyc("R6", 0, 8'h04, 0, 0, 64, 0); check("R6", regRdata, 32'h04);
    cyc("R6", 1, 8'h04, 32'h04, 0, 64, 0);

    // R7 full at exactly depth
    cyc("R7", 0, 8'h04, 0, 0, 127, 0);
    cyc("R7", 0, 8'h04, 0, 0, 128, 0); check("R7", regRdata, 32'h00);
    cyc("R7", 0, 8'h04, 0, 0, 64, 0);  check("R7", regRdata, 32'h08);
    cyc("R7", 1, 8'h04, 32'h08, 0, 64, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [6:0] p;
      logic [7:0] tx, rx, a;
      logic [31:0] d;
      op = $urandom % 8;
      p  = ($urandom % 6 == 0) ? 7'($urandom) : 7'd0;
      case ($urandom % 6)
        0: tx = 8'd0;
        1: tx = mThr;
        2: tx = mThr - 8'd1;
        3: tx = 8'd128;
        4: tx = 8'd127;
        default: tx = 8'($urandom % 129);
      endcase
      rx = ($urandom % 3 == 0) ? 8'($urandom % 129) : 8'd0;
      d  = $urandom;
      case (op)
        0, 1: cyc("R2", 0, 8'h04, 0, p, tx, rx);
        2:    cyc("R5", 0, 8'h10, 0, p, tx, rx);
        3:    cyc("R6", 0, 8'h28, 0, p, tx, rx);
        4:    cyc("R3", 1, 8'h04, ($urandom % 2) ? {25'd0, mSts} : d, p, tx, rx);
        5:    cyc("R5", 1, 8'h08, d, p, tx, rx);
        6:    cyc("R5", 1, 8'h0C, d, p, tx, rx);
        default: begin
          a = ($urandom % 2) ? 8'h28 : 8'($urandom);
          cyc("R11", 1, a, {24'd0, 8'($urandom % 140)}, p, tx, rx);
        end
      endcase
    end

    done = 1'b1;
    finishRun();
  end
endmodule